// File: doc/BRIEF.md
# Buffered Output Compare Channel Pair

This block is a timer with a free-running 16-bit up-counter and two output compare channels. Each channel compares the counter with its own compare register and drives its own pin. When the count matches, the pin toggles, clears or sets. An optional mode inverts the pin on every counter wrap, which turns a channel into a PWM source.

The two channels can be linked into one buffered channel. The two compare registers then take turns driving the first pin. The register that software wrote most recently takes over only when the counter wraps. This lets software stage a new duty cycle without producing a short or double pulse in the current period.

While the channels are linked, the second pin is handed over to general-purpose I/O. The second channel's control register is ignored. All configuration arrives through a single-cycle register write port.

Top module: `bocp_timer`

## Requirements
- R1: After reset, the counter is 0, the modulo is all ones, both compare and both control registers are 0, both pins are low, `gpio_b_en` is low and `ovf` is low.
- R2: The counter advances by one each clock. It wraps to 0 on the clock after it holds a value greater than or equal to the modulo. `ovf` is high exactly in the cycles in which that wrapping value is held.
- R3: Register addresses: 0 modulo, 1 first compare, 2 second compare, 3 first control, 4 second control. In each control register, bits [2:1] select the action applied to the pin when the counter equals the active compare value: 00 none, 01 toggle, 10 clear, 11 set. Bit 3 inverts the pin in every wrap cycle. The inversion is applied after the compare action, and both take effect at the same clock edge.
- R4: Bit 0 of the first control register links the pair. When this bit goes from 0 to 1, the first compare register becomes the active one and counts as the last one written.
- R5: While the pair is linked, a write to the inactive compare register has no effect on the pin until the next wrap. The handover takes place at the edge that ends the wrap cycle.
- R6: At each wrap while linked, the active register becomes the one written last. If both were written since the previous wrap, the later write wins. If neither was written, the active register does not change.
- R7: A write to the currently active compare register is used for comparison from the next cycle on, exactly as in unbuffered operation.
- R8: While linked, the first pin uses only the first control register's action and wrap-inversion bits. The second control register is ignored, the second pin holds its value, and `gpio_b_en` is high.
- R9: Clearing the link bit returns both channels to independent operation on their own compare and control registers, and drives `gpio_b_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data; control registers use bits [3:0] |
| cmp_out_a | output | 1 | First pin: channel output, or buffered output when linked |
| cmp_out_b | output | 1 | Second pin: channel output when unlinked |
| ovf | output | 1 | High in the counter's wrap cycle |
| gpio_b_en | output | 1 | Second pin released to general-purpose I/O |

## Verification
The unlinked phases use each of the four compare actions, with and without wrap inversion. These phases separate a wrong action decode from a wrong ordering of the compare action and the inversion. A shrinking modulo shows whether the wrap uses a greater-or-equal test rather than strict equality. The linked phases write the inactive register in the middle of a period, write both registers in each order before one wrap, write neither register, and write the active register. Together these distinguish an immediate handover from one taken at the wrap, a first-write priority from a last-write priority, and a handover that fires spuriously. A write to the second control register while linked shows whether the released pin is really frozen.

// File: rtl/bocp_pkg.sv
package bocp_pkg;
  localparam int CTRL_W = 4;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MOD   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP_A = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP_B = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTL_A = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTL_B = 3'd4;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } pin_act_e;

  typedef struct packed {
    logic     tov;
    pin_act_e act;
    logic     link;
  } ctl_t;

  function automatic logic next_pin(input logic cur, input logic hit,
                                    input pin_act_e act, input logic inv);
    logic v;
    v = cur;
    if (hit) begin
      case (act)
        ACT_TOGGLE: v = ~cur;
        ACT_CLEAR:  v = 1'b0;
        ACT_SET:    v = 1'b1;
        default:    v = cur;
      endcase
    end
    return inv ? ~v : v;
  endfunction
endpackage

// File: rtl/bocp_counter.sv
module bocp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = (cnt >= modulo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bocp_link_ctrl.sv
module bocp_link_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic link,
  input  logic link_rise,
  input  logic wrap,
  input  logic wr_cmp_a,
  input  logic wr_cmp_b,
  output logic act_sel
);
  logic last_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= 1'b0;
      last_b  <= 1'b0;
    end else begin
      if (link_rise)         act_sel <= 1'b0;
      else if (link && wrap) act_sel <= last_b;

      if (link_rise)     last_b <= 1'b0;
      else if (wr_cmp_a) last_b <= 1'b0;
      else if (wr_cmp_b) last_b <= 1'b1;
    end
  end
endmodule

// File: rtl/bocp_pin.sv
module bocp_pin
  import bocp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  pin_act_e         act,
  input  logic             tov,
  input  logic             wrap,
  output logic             hit,
  output logic             pin
);
  assign hit = (cnt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pin <= 1'b0;
    else if (en) pin <= next_pin(pin, hit, act, tov && wrap);
  end
endmodule

// File: rtl/bocp_timer.sv
module bocp_timer
  import bocp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  output logic                cmp_out_a,
  output logic                cmp_out_b,
  output logic                ovf,
  output logic                gpio_b_en
);
  localparam int NCH = 2;

  logic [CNT_W-1:0] mod_q, cmp_a_q, cmp_b_q;
  ctl_t             ctl_a_q, ctl_b_q;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             link, link_rise, act_sel;
  logic             wr_cmp_a, wr_cmp_b, wr_ctl_a;

  assign wr_cmp_a  = wr_en && (wr_addr == A_CMP_A);
  assign wr_cmp_b  = wr_en && (wr_addr == A_CMP_B);
  assign wr_ctl_a  = wr_en && (wr_addr == A_CTL_A);
  assign link      = ctl_a_q.link;
  assign link_rise = wr_ctl_a && wr_data[0] && !link;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q   <= '1;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      ctl_a_q <= '0;
      ctl_b_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MOD:   mod_q   <= wr_data;
        A_CMP_A: cmp_a_q <= wr_data;
        A_CMP_B: cmp_b_q <= wr_data;
        A_CTL_A: ctl_a_q <= ctl_t'(wr_data[CTRL_W-1:0]);
        A_CTL_B: ctl_b_q <= ctl_t'(wr_data[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  bocp_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .modulo(mod_q), .cnt(cnt), .wrap(wrap)
  );

  bocp_link_ctrl link_i (
    .clk(clk), .rst_n(rst_n), .link(link), .link_rise(link_rise),
    .wrap(wrap), .wr_cmp_a(wr_cmp_a), .wr_cmp_b(wr_cmp_b), .act_sel(act_sel)
  );

  logic [CNT_W-1:0] ch_cmp [NCH];
  pin_act_e         ch_act [NCH];
  logic [NCH-1:0]   ch_tov, ch_en, ch_hit, ch_pin;

  assign ch_cmp[0] = (link && act_sel) ? cmp_b_q : cmp_a_q;
  assign ch_act[0] = ctl_a_q.act;
  assign ch_tov[0] = ctl_a_q.tov;
  assign ch_en[0]  = 1'b1;
  assign ch_cmp[1] = cmp_b_q;
  assign ch_act[1] = ctl_b_q.act;
  assign ch_tov[1] = ctl_b_q.tov;
  assign ch_en[1]  = !link;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    bocp_pin #(.CNT_W(CNT_W)) pin_i (
      .clk(clk), .rst_n(rst_n), .en(ch_en[g]), .cnt(cnt), .cmp(ch_cmp[g]),
      .act(ch_act[g]), .tov(ch_tov[g]), .wrap(wrap),
      .hit(ch_hit[g]), .pin(ch_pin[g])
    );
  end

  logic hit_a, tov_a;
  assign hit_a     = ch_hit[0];
  assign tov_a     = ch_tov[0];
  assign cmp_out_a = ch_pin[0];
  assign cmp_out_b = ch_pin[1];
  assign ovf       = wrap;
  assign gpio_b_en = link;
endmodule

// File: rtl/bocp_checker.sv
module bocp_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic             link,
  input logic             link_rise,
  input logic             act_sel,
  input logic             hit_a,
  input logic             tov_a,
  input logic             cmp_out_a,
  input logic             cmp_out_b
);
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0)); // R2

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_a && !(wrap && tov_a)) |=> $stable(cmp_out_a)); // R3

  AST_LINK_STARTS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    link_rise |=> (act_sel == 1'b0)); // R4

  AST_NO_MIDPERIOD_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !link_rise) |=> $stable(act_sel)); // R5

  AST_FREED_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    link |=> (!link || $stable(cmp_out_b))); // R8
endmodule

bind bocp_timer bocp_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wrap(wrap), .cnt(cnt), .link(link),
  .link_rise(link_rise), .act_sel(act_sel), .hit_a(hit_a), .tov_a(tov_a),
  .cmp_out_a(cmp_out_a), .cmp_out_b(cmp_out_b)
);

// File: tb/bocp_timer_tb.sv
module bocp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cmp_out_a, cmp_out_b, ovf, gpio_b_en;

  always #2 clk = ~clk;

  bocp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmp_out_a(cmp_out_a), .cmp_out_b(cmp_out_b),
    .ovf(ovf), .gpio_b_en(gpio_b_en)
  );

  int    checks = 0;
  int    fails  = 0;
  string phase  = "R1";

  // Behavioural reference state
  int m_cnt = 0, m_mod = 16'hFFFF, m_ca = 0, m_cb = 0, m_kta = 0, m_ktb = 0;
  bit m_oa = 0, m_ob = 0, m_act_b = 0, m_last_b = 0;

  function automatic bit apply(bit cur, bit hit, int code, bit inv);
    bit r;
    r = cur;
    if (hit && code == 1) r = !cur;
    if (hit && code == 2) r = 0;
    if (hit && code == 3) r = 1;
    if (inv) r = !r;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_mod = 16'hFFFF; m_ca = 0; m_cb = 0; m_kta = 0; m_ktb = 0;
      m_oa = 0; m_ob = 0; m_act_b = 0; m_last_b = 0;
    end else begin
      bit w, lk, na, nb, nact, nlast;
      int cur_cmp;
      w  = (m_cnt >= m_mod);
      lk = m_kta[0];
      cur_cmp = (lk && m_act_b) ? m_cb : m_ca;
      na = apply(m_oa, m_cnt == cur_cmp, (m_kta >> 1) & 3, m_kta[3] && w);
      nb = lk ? m_ob : apply(m_ob, m_cnt == m_cb, (m_ktb >> 1) & 3, m_ktb[3] && w);
      nact  = (lk && w) ? m_last_b : m_act_b;
      nlast = m_last_b;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_mod = wr_data;
          3'd1: begin m_ca = wr_data; nlast = 0; end
          3'd2: begin m_cb = wr_data; nlast = 1; end
          3'd3: begin
            if (wr_data[0] && !lk) begin nact = 0; nlast = 0; end
            m_kta = wr_data[3:0];
          end
          3'd4: m_ktb = wr_data[3:0];
          default: ;
        endcase
      end
      m_cnt = w ? 0 : (m_cnt + 1) & 16'hFFFF;
      m_oa = na; m_ob = nb; m_act_b = nact; m_last_b = nlast;
    end
  end

  task automatic check(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", phase, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    check("cmp_out_a", cmp_out_a, m_oa);
    check("cmp_out_b", cmp_out_b, m_ob);
    check("ovf", ovf, m_cnt >= m_mod);
    check("gpio_b_en", gpio_b_en, m_kta[0]);
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    phase = "R1";                       // reset state
    idle(3);
    rst_n = 1'b1;
    idle(2);
    phase = "R2";                       // counter wrap at modulo
    wr(0, 9);   idle(25);
    phase = "R3";                       // all actions, with/without inversion
    wr(1, 3);   wr(3, 4'b0010);
    wr(2, 5);   wr(4, 4'b0110); idle(30);
    wr(3, 4'b0100); wr(4, 4'b1010); idle(30);
    wr(3, 4'b1110); wr(4, 4'b0000); idle(30);
    phase = "R2";                       // shrink modulo below count
    idle(5); wr(0, 3); idle(12); wr(0, 9); idle(12);
    phase = "R4";                       // link: first register drives pin
    wr(3, 4'b1101); idle(25);
    phase = "R5";                       // stage second register mid-period
    idle(4); wr(2, 7); idle(25);
    phase = "R6";                       // both written, either order; neither
    wr(1, 2); wr(2, 8); idle(12);
    wr(2, 4); wr(1, 6); idle(12);
    idle(30);
    phase = "R7";                       // active register written
    wr(1, 8); idle(12); wr(1, 1); idle(12);
    phase = "R8";                       // second control ignored
    wr(4, 4'b1110); wr(2, 3); idle(25);
    phase = "R9";                       // unlink restores independence
    wr(3, 4'b0010); idle(30); wr(4, 4'b0010); idle(25);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule